// File: doc/BRIEF.md
# Fault-Injection Run Supervisor

This block sequences one upset-injection experiment at a time against a processor that runs a self-checking workload. Software loads a small table of injection vectors, the expected result words and three timing settings through a single write port, then arms a run by naming one vector. The supervisor releases the processor from reset, waits for it to report that boot has finished, counts the workload's run cycles, and at the programmed instant fires an interrupt while presenting which resource, which register and which bit mask the interrupt routine should flip.

A run ends in one of three ways: the processor signals completion, the run stage overruns its limit, or boot never finishes within its own limit. After a completion the supervisor reads the result words back one per cycle and compares them with the stored expected words. Every run lands in exactly one of four outcome counters. Between runs the processor is parked in reset. A host watchdog must be refreshed; if it lapses, the campaign is aborted for good until reset.

Top module: `fis_supervisor`

## Requirements
- R1: After synchronous reset the processor reset output is high, the interrupt, injection-valid and run-done outputs are low, the watchdog fault is low and all four outcome counters read zero.
- R2: A configuration write (`cfg_we_i`) stores `cfg_wdata_i` by kind: 0 instant (bits 15:0, vector `cfg_idx_i`), 1 target code (bits 2:0), 2 register id (bits 7:0), 3 bit mask (32 bits), 4 expected word `cfg_idx_i`, 5 nominal run time in cycles (bits 15:0), 6 run-limit multiple (bits 3:0, reset value 5), 7 boot limit in cycles (bits 15:0). Target codes are 0 register file, 1 program counter, 2 next program counter, 3 instruction cache, 4 data cache.
- R3: An arm pulse in idle with no watchdog fault latches vector `arm_idx_i` and the limits, and drives the processor reset output low from the next cycle (boot cycle 0).
- R4: Boot cycles are numbered from 0; `boot_done_i` seen in boot cycles 0 to L-1 (L the boot limit) starts the run stage in the next cycle, while reaching boot cycle L is a boot timeout.
- R5: Run cycles are numbered from 0; the interrupt is a one-cycle pulse in run cycle instant+1, given at most once per run and only if the run is still going at run cycle instant.
- R6: From the interrupt cycle the injection-valid output is high and the target, register and mask outputs hold the armed vector's fields unchanged until the cycle after `inj_ack_i` is seen, when valid drops.
- R7: The run limit is nominal time times the multiple; `app_end_i` seen in run cycles 0 to limit-1 starts the result check, while reaching run cycle limit is a run timeout even if `app_end_i` is high in that cycle.
- R8: The result check reads addresses 0 to NUM_RES-1 on `res_rd_addr_o`, one per cycle, with data returned in the same cycle; any word that differs from its expected word makes the run an error, otherwise it is correct.
- R9: Each finished run pulses `run_done_o` for one cycle and increments exactly one counter on the following edge, chosen with priority boot timeout, run timeout, error, correct.
- R10: After a run the processor reset output stays high until the next arm.
- R11: If `host_kick_i` is absent for WD_WINDOW consecutive cycles a sticky watchdog fault is set; the current run is dropped without counting, the processor is held in reset and arm is ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 3 | Configuration item kind (R2) |
| cfg_idx_i | input | CIDX_W (2) | Vector or expected-word index |
| cfg_wdata_i | input | 32 | Configuration write data |
| arm_i | input | 1 | Start a run |
| arm_idx_i | input | VIDX_W (2) | Vector used by the run |
| dut_rst_o | output | 1 | Processor reset, high = held |
| irq_o | output | 1 | Injection interrupt pulse |
| inj_valid_o | output | 1 | Injection fields pending acknowledge |
| inj_target_o | output | 3 | Target resource code |
| inj_reg_o | output | 8 | Register identifier |
| inj_mask_o | output | 32 | Bit mask to XOR into the target |
| inj_ack_i | input | 1 | Processor took the injection fields |
| boot_done_i | input | 1 | Processor finished boot |
| app_end_i | input | 1 | Workload completed normally |
| res_rd_addr_o | output | RIDX_W (2) | Result word address |
| res_rd_data_i | input | 32 | Result word, same cycle |
| host_kick_i | input | 1 | Host watchdog refresh |
| wd_fault_o | output | 1 | Sticky watchdog fault |
| run_done_o | output | 1 | One-cycle end-of-run pulse |
| cnt_boot_to_o | output | CNT_W (16) | Boot timeout count |
| cnt_run_to_o | output | CNT_W (16) | Run timeout count |
| cnt_err_o | output | CNT_W (16) | Erroneous result count |
| cnt_ok_o | output | CNT_W (16) | Correct run count |

## Verification
Runs are driven from a table that varies the boot delay, the completion cycle, the injection instant and which result word, if any, is corrupted. Completion one cycle before the limit versus at the limit, and boot done one cycle before versus at the boot limit, separate a correct finish from each timeout; a corrupted first or last word separates error from correct, and a corrupted word on a timed-out run shows the priority. Instants earlier and later than the run's end tell a due interrupt from a suppressed one, and a reduced multiple shows the limit follows the programmed product. A lapsed host refresh during a long run shows the abort leaves the counters untouched and the processor parked.

// File: rtl/fis_pkg.sv
package fis_pkg;

    localparam int DATA_W = 32;
    localparam int INST_W = 16;
    localparam int REG_W  = 8;
    localparam int TGT_W  = 3;
    localparam int MULT_W = 4;
    localparam int LIM_W  = INST_W + MULT_W;

    typedef enum logic [TGT_W-1:0] {
        TGT_REGFILE = 3'd0,
        TGT_PC      = 3'd1,
        TGT_NPC     = 3'd2,
        TGT_ICACHE  = 3'd3,
        TGT_DCACHE  = 3'd4
    } tgt_e;

    typedef enum logic [2:0] {
        CFG_INSTANT = 3'd0,
        CFG_TARGET  = 3'd1,
        CFG_REGID   = 3'd2,
        CFG_MASK    = 3'd3,
        CFG_EXPECT  = 3'd4,
        CFG_NOMINAL = 3'd5,
        CFG_MULT    = 3'd6,
        CFG_BOOTLIM = 3'd7
    } cfg_kind_e;

    typedef struct packed {
        logic [INST_W-1:0] instant;
        logic [TGT_W-1:0]  target;
        logic [REG_W-1:0]  reg_id;
        logic [DATA_W-1:0] mask;
    } inj_vec_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BOOT,
        ST_RUN,
        ST_CHECK,
        ST_DONE
    } sup_state_e;

    typedef enum logic [1:0] {
        OUT_BOOT_TO = 2'd0,
        OUT_RUN_TO  = 2'd1,
        OUT_ERROR   = 2'd2,
        OUT_CORRECT = 2'd3
    } outcome_e;

    function automatic logic [LIM_W-1:0] run_limit(input logic [INST_W-1:0] nominal,
                                                   input logic [MULT_W-1:0] mult);
        return LIM_W'(nominal) * LIM_W'(mult);
    endfunction

endpackage

// File: rtl/fis_cfg_store.sv
module fis_cfg_store
    import fis_pkg::*;
#(
    parameter int NUM_VEC  = 4,
    parameter int NUM_RES  = 4,
    parameter int NOM_DEF  = 16,
    parameter int MULT_DEF = 5,
    parameter int BOOT_DEF = 64,
    localparam int VIDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
    localparam int RIDX_W = (NUM_RES > 1) ? $clog2(NUM_RES) : 1,
    localparam int CIDX_W = (VIDX_W > RIDX_W) ? VIDX_W : RIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  cfg_kind_e         kind,
    input  logic [CIDX_W-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [VIDX_W-1:0] vec_idx,
    output inj_vec_t          vec_o,
    input  logic [RIDX_W-1:0] exp_idx,
    output logic [DATA_W-1:0] exp_o,
    output logic [INST_W-1:0] nominal_o,
    output logic [MULT_W-1:0] mult_o,
    output logic [INST_W-1:0] boot_lim_o
);

    inj_vec_t          vec_q [NUM_VEC];
    logic [DATA_W-1:0] exp_q [NUM_RES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int v = 0; v < NUM_VEC; v++) vec_q[v] <= '0;
            for (int r = 0; r < NUM_RES; r++) exp_q[r] <= '0;
            nominal_o  <= INST_W'(NOM_DEF);
            mult_o     <= MULT_W'(MULT_DEF);
            boot_lim_o <= INST_W'(BOOT_DEF);
        end else if (we) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                if (idx == CIDX_W'(v)) begin
                    case (kind)
                        CFG_INSTANT: vec_q[v].instant <= wdata[INST_W-1:0];
                        CFG_TARGET:  vec_q[v].target  <= wdata[TGT_W-1:0];
                        CFG_REGID:   vec_q[v].reg_id  <= wdata[REG_W-1:0];
                        CFG_MASK:    vec_q[v].mask    <= wdata;
                        default: ;
                    endcase
                end
            end
            for (int r = 0; r < NUM_RES; r++) begin
                if (kind == CFG_EXPECT && idx == CIDX_W'(r)) exp_q[r] <= wdata;
            end
            case (kind)
                CFG_NOMINAL: nominal_o  <= wdata[INST_W-1:0];
                CFG_MULT:    mult_o     <= wdata[MULT_W-1:0];
                CFG_BOOTLIM: boot_lim_o <= wdata[INST_W-1:0];
                default: ;
            endcase
        end
    end

    assign vec_o = vec_q[vec_idx];
    assign exp_o = exp_q[exp_idx];

endmodule

// File: rtl/fis_result_cmp.sv
module fis_result_cmp
    import fis_pkg::*;
#(
    parameter int NUM_RES = 4,
    localparam int RIDX_W = (NUM_RES > 1) ? $clog2(NUM_RES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    output logic [RIDX_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic [DATA_W-1:0] exp_i,
    output logic              done_o,
    output logic              mismatch_o
);

    localparam logic [RIDX_W-1:0] LAST = RIDX_W'(NUM_RES - 1);

    logic              busy_q;
    logic [RIDX_W-1:0] idx_q;
    logic              acc_q;
    logic              diff;

    assign diff      = (rd_data_i != exp_i);
    assign rd_addr_o = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            idx_q      <= '0;
            acc_q      <= 1'b0;
            done_o     <= 1'b0;
            mismatch_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go_i && !busy_q) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                acc_q  <= 1'b0;
            end else if (busy_q) begin
                if (idx_q == LAST) begin
                    busy_q     <= 1'b0;
                    done_o     <= 1'b1;
                    mismatch_o <= acc_q | diff;
                    idx_q      <= '0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                    acc_q <= acc_q | diff;
                end
            end
        end
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_addr_range_R8: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (idx_q <= LAST));

endmodule

// File: rtl/fis_watchdog.sv
module fis_watchdog #(
    parameter int WINDOW = 4096,
    localparam int CW = $clog2(WINDOW + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_i,
    output logic fault_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            fault_o <= 1'b0;
        end else if (kick_i) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(WINDOW - 1)) begin
            fault_o <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> fault_o);

endmodule

// File: rtl/fis_supervisor.sv
module fis_supervisor
    import fis_pkg::*;
#(
    parameter int NUM_VEC   = 4,
    parameter int NUM_RES   = 4,
    parameter int CNT_W     = 16,
    parameter int WD_WINDOW = 4096,
    parameter int NOM_DEF   = 16,
    parameter int MULT_DEF  = 5,
    parameter int BOOT_DEF  = 64,
    localparam int VIDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
    localparam int RIDX_W = (NUM_RES > 1) ? $clog2(NUM_RES) : 1,
    localparam int CIDX_W = (VIDX_W > RIDX_W) ? VIDX_W : RIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we_i,
    input  logic [2:0]        cfg_kind_i,
    input  logic [CIDX_W-1:0] cfg_idx_i,
    input  logic [31:0]       cfg_wdata_i,
    input  logic              arm_i,
    input  logic [VIDX_W-1:0] arm_idx_i,
    output logic              dut_rst_o,
    output logic              irq_o,
    output logic              inj_valid_o,
    output logic [2:0]        inj_target_o,
    output logic [7:0]        inj_reg_o,
    output logic [31:0]       inj_mask_o,
    input  logic              inj_ack_i,
    input  logic              boot_done_i,
    input  logic              app_end_i,
    output logic [RIDX_W-1:0] res_rd_addr_o,
    input  logic [31:0]       res_rd_data_i,
    input  logic              host_kick_i,
    output logic              wd_fault_o,
    output logic              run_done_o,
    output logic [CNT_W-1:0]  cnt_boot_to_o,
    output logic [CNT_W-1:0]  cnt_run_to_o,
    output logic [CNT_W-1:0]  cnt_err_o,
    output logic [CNT_W-1:0]  cnt_ok_o
);

    inj_vec_t          vec_rd;
    logic [DATA_W-1:0] exp_word;
    logic [INST_W-1:0] nominal, boot_lim;
    logic [MULT_W-1:0] mult;
    logic              cmp_go, cmp_done, cmp_mismatch;

    sup_state_e        st_q;
    inj_vec_t          run_vec_q;
    logic [LIM_W-1:0]  limit_q, run_cnt_q;
    logic [INST_W-1:0] boot_lim_q, boot_cnt_q;
    logic              fired_q, irq_q, pend_q;
    outcome_e          outc_q;
    logic              boot_over, run_over;

    fis_cfg_store #(
        .NUM_VEC(NUM_VEC), .NUM_RES(NUM_RES),
        .NOM_DEF(NOM_DEF), .MULT_DEF(MULT_DEF), .BOOT_DEF(BOOT_DEF)
    ) i_cfg (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we_i),
        .kind      (cfg_kind_e'(cfg_kind_i)),
        .idx       (cfg_idx_i),
        .wdata     (cfg_wdata_i),
        .vec_idx   (arm_idx_i),
        .vec_o     (vec_rd),
        .exp_idx   (res_rd_addr_o),
        .exp_o     (exp_word),
        .nominal_o (nominal),
        .mult_o    (mult),
        .boot_lim_o(boot_lim)
    );

    fis_result_cmp #(.NUM_RES(NUM_RES)) i_cmp (
        .clk       (clk),
        .rst       (rst),
        .go_i      (cmp_go),
        .rd_addr_o (res_rd_addr_o),
        .rd_data_i (res_rd_data_i),
        .exp_i     (exp_word),
        .done_o    (cmp_done),
        .mismatch_o(cmp_mismatch)
    );

    fis_watchdog #(.WINDOW(WD_WINDOW)) i_wd (
        .clk    (clk),
        .rst    (rst),
        .kick_i (host_kick_i),
        .fault_o(wd_fault_o)
    );

    assign boot_over = (boot_cnt_q >= boot_lim_q);
    assign run_over  = (run_cnt_q >= limit_q);
    assign cmp_go    = (st_q == ST_RUN) && !run_over && app_end_i && !wd_fault_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            run_vec_q  <= '0;
            limit_q    <= '0;
            run_cnt_q  <= '0;
            boot_lim_q <= '0;
            boot_cnt_q <= '0;
            fired_q    <= 1'b0;
            irq_q      <= 1'b0;
            pend_q     <= 1'b0;
            outc_q     <= OUT_CORRECT;
        end else begin
            irq_q <= 1'b0;
            if (inj_ack_i) pend_q <= 1'b0;
            if (wd_fault_o) begin
                st_q   <= ST_IDLE;
                pend_q <= 1'b0;
            end else begin
                case (st_q)
                    ST_IDLE: begin
                        if (arm_i) begin
                            st_q       <= ST_BOOT;
                            run_vec_q  <= vec_rd;
                            limit_q    <= run_limit(nominal, mult);
                            boot_lim_q <= boot_lim;
                            boot_cnt_q <= '0;
                            fired_q    <= 1'b0;
                            pend_q     <= 1'b0;
                        end
                    end
                    ST_BOOT: begin
                        if (boot_over) begin
                            outc_q <= OUT_BOOT_TO;
                            st_q   <= ST_DONE;
                        end else if (boot_done_i) begin
                            st_q      <= ST_RUN;
                            run_cnt_q <= '0;
                        end else begin
                            boot_cnt_q <= boot_cnt_q + 1'b1;
                        end
                    end
                    ST_RUN: begin
                        if (run_over) begin
                            outc_q <= OUT_RUN_TO;
                            st_q   <= ST_DONE;
                            pend_q <= 1'b0;
                        end else if (app_end_i) begin
                            st_q   <= ST_CHECK;
                            pend_q <= 1'b0;
                        end else begin
                            run_cnt_q <= run_cnt_q + 1'b1;
                            if (!fired_q && run_cnt_q == LIM_W'(run_vec_q.instant)) begin
                                irq_q   <= 1'b1;
                                fired_q <= 1'b1;
                                pend_q  <= 1'b1;
                            end
                        end
                    end
                    ST_CHECK: begin
                        if (cmp_done) begin
                            outc_q <= cmp_mismatch ? OUT_ERROR : OUT_CORRECT;
                            st_q   <= ST_DONE;
                        end
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign run_done_o = (st_q == ST_DONE) && !wd_fault_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_boot_to_o <= '0;
            cnt_run_to_o  <= '0;
            cnt_err_o     <= '0;
            cnt_ok_o      <= '0;
        end else if (run_done_o) begin
            case (outc_q)
                OUT_BOOT_TO: cnt_boot_to_o <= cnt_boot_to_o + 1'b1;
                OUT_RUN_TO:  cnt_run_to_o  <= cnt_run_to_o + 1'b1;
                OUT_ERROR:   cnt_err_o     <= cnt_err_o + 1'b1;
                default:     cnt_ok_o      <= cnt_ok_o + 1'b1;
            endcase
        end
    end

    assign dut_rst_o    = wd_fault_o || !(st_q == ST_BOOT || st_q == ST_RUN);
    assign irq_o        = irq_q && !wd_fault_o;
    assign inj_valid_o  = pend_q;
    assign inj_target_o = run_vec_q.target;
    assign inj_reg_o    = run_vec_q.reg_id;
    assign inj_mask_o   = run_vec_q.mask;

    assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    assert_irq_live_R5: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !dut_rst_o);

    assert_fields_hold_R6: assert property (@(posedge clk) disable iff (rst)
        inj_valid_o && !inj_ack_i |=>
            $stable(inj_mask_o) && $stable(inj_reg_o) && $stable(inj_target_o));

    assert_boot_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BOOT) |-> (boot_cnt_q <= boot_lim_q));

    assert_run_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN) |-> (run_cnt_q <= limit_q));

    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
        run_done_o |=> $countones({cnt_boot_to_o != $past(cnt_boot_to_o),
                                   cnt_run_to_o  != $past(cnt_run_to_o),
                                   cnt_err_o     != $past(cnt_err_o),
                                   cnt_ok_o      != $past(cnt_ok_o)}) == 1);

    assert_count_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !run_done_o |=> $stable(cnt_boot_to_o) && $stable(cnt_run_to_o) &&
                        $stable(cnt_err_o) && $stable(cnt_ok_o));

    assert_fault_parks_R11: assert property (@(posedge clk) disable iff (rst)
        wd_fault_o |=> dut_rst_o && !run_done_o && !irq_o);

endmodule

// File: tb/test_fis_supervisor.sv
`timescale 1ns/1ps
module test_fis_supervisor;
    import fis_pkg::*;

    localparam int NR   = 4;
    localparam int CW   = 16;
    localparam int WDW  = 64;
    localparam int BLIM = 6;
    localparam int NOM  = 4;
    localparam int LIM  = NOM * 5;

    localparam int INST [4] = '{3, 7, 9, 30};
    localparam int TGTC [4] = '{0, 1, 4, 3};

    // run table: vector, boot cycle of boot_done, run cycle of app_end,
    // corrupted word (-1 none), outcome (0 boot to, 1 run to, 2 error, 3 correct)
    localparam int NROW = 8;
    localparam int T_VEC  [8] = '{0, 1, 2, 3, 0, 1, 2, 3};
    localparam int T_BOOT [8] = '{2, 0, 6, 3, 1, 5, 1, 0};
    localparam int T_END  [8] = '{10, 12, 0, 21, 19, 20, 2, 5};
    localparam int T_BAD  [8] = '{-1, 2, -1, -1, -1, 0, -1, 3};
    localparam int T_OUT  [8] = '{3, 2, 0, 1, 3, 1, 3, 2};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_kind = '0;
    logic [1:0] cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic arm = 1'b0;
    logic [1:0] arm_idx = '0;
    logic dut_rst_o, irq_o, inj_valid_o, wd_fault_o, run_done_o;
    logic [2:0] inj_target_o;
    logic [7:0] inj_reg_o;
    logic [31:0] inj_mask_o;
    logic inj_ack = 1'b0, boot_done = 1'b0, app_end = 1'b0, kick = 1'b0;
    logic [1:0] res_rd_addr;
    logic [31:0] res_rd_data;
    logic [31:0] res_mem [NR];
    logic [CW-1:0] c_boot, c_run, c_err, c_ok;

    bit kick_en = 1'b1;
    int checks = 0;
    int fails  = 0;
    int exp_cnt [4] = '{0, 0, 0, 0};

    always #4 clk = ~clk;

    assign res_rd_data = res_mem[res_rd_addr];

    fis_supervisor #(.WD_WINDOW(WDW)) i_fis_supervisor (
        .clk(clk), .rst(rst),
        .cfg_we_i(cfg_we), .cfg_kind_i(cfg_kind), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
        .arm_i(arm), .arm_idx_i(arm_idx),
        .dut_rst_o(dut_rst_o), .irq_o(irq_o), .inj_valid_o(inj_valid_o),
        .inj_target_o(inj_target_o), .inj_reg_o(inj_reg_o), .inj_mask_o(inj_mask_o),
        .inj_ack_i(inj_ack), .boot_done_i(boot_done), .app_end_i(app_end),
        .res_rd_addr_o(res_rd_addr), .res_rd_data_i(res_rd_data),
        .host_kick_i(kick), .wd_fault_o(wd_fault_o), .run_done_o(run_done_o),
        .cnt_boot_to_o(c_boot), .cnt_run_to_o(c_run), .cnt_err_o(c_err), .cnt_ok_o(c_ok)
    );

    function automatic logic [31:0] exp_word(input int w);
        return 32'hA5A5_0000 + 32'(w);
    endfunction
    function automatic logic [31:0] vmask(input int v);
        return 32'h1 << (v * 5 + 1);
    endfunction
    function automatic logic [7:0] vreg(input int v);
        return 8'h10 + 8'(v);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic cfg_write(input logic [2:0] kind, input int idx, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = kind; cfg_idx = idx[1:0]; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic check_counters(input string req);
        chk(c_boot == CW'(exp_cnt[0]), req, c_boot, exp_cnt[0]);
        chk(c_run  == CW'(exp_cnt[1]), req, c_run,  exp_cnt[1]);
        chk(c_err  == CW'(exp_cnt[2]), req, c_err,  exp_cnt[2]);
        chk(c_ok   == CW'(exp_cnt[3]), req, c_ok,   exp_cnt[3]);
    endtask

    task automatic do_run(input int vidx, input int boot_at, input int end_at,
                          input int bad, input int outc, input int lim);
        int irq_c, irq_n, wait_n;
        bit done_seen, exp_irq;
        string tag;
        for (int w = 0; w < NR; w++)
            res_mem[w] = exp_word(w) ^ ((w == bad) ? 32'h1 : 32'h0);
        @(negedge clk);
        arm = 1'b1; arm_idx = vidx[1:0];
        @(negedge clk);
        arm = 1'b0;
        chk(dut_rst_o == 1'b0, "R3", dut_rst_o, 0);
        repeat (boot_at) @(negedge clk);
        boot_done = 1'b1;
        @(negedge clk);
        boot_done = 1'b0;
        done_seen = 1'b0;
        if (outc != 0) begin
            irq_c = -1; irq_n = 0;
            for (int c = 0; c <= end_at; c++) begin
                if (run_done_o) done_seen = 1'b1;
                if (irq_o) begin
                    irq_n++; irq_c = c;
                    chk(c == INST[vidx] + 1, "R5", c, INST[vidx] + 1);
                    chk(inj_valid_o && inj_mask_o == vmask(vidx) && inj_reg_o == vreg(vidx)
                        && inj_target_o == 3'(TGTC[vidx]), "R6", inj_mask_o, vmask(vidx));
                end
                if (irq_c >= 0 && c == irq_c + 2) begin
                    chk(inj_valid_o && inj_mask_o == vmask(vidx), "R6", inj_valid_o, 1);
                    inj_ack = 1'b1;
                end
                if (irq_c >= 0 && c == irq_c + 3) begin
                    inj_ack = 1'b0;
                    chk(!inj_valid_o, "R6", inj_valid_o, 0);
                end
                app_end = (c == end_at);
                @(negedge clk);
            end
            app_end = 1'b0; inj_ack = 1'b0;
            exp_irq = (INST[vidx] < end_at) && (INST[vidx] < lim);
            chk(irq_n == int'(exp_irq), "R5", irq_n, int'(exp_irq));
        end
        wait_n = 0;
        while (!done_seen && !run_done_o && wait_n < 50) begin
            @(negedge clk);
            wait_n++;
        end
        chk(done_seen || run_done_o, "R9", 0, 1);
        if (!done_seen) @(negedge clk);
        exp_cnt[outc]++;
        case (outc)
            0: tag = "R4 R9";
            1: tag = "R7 R9";
            default: tag = "R8 R9";
        endcase
        check_counters(tag);
        chk(dut_rst_o == 1'b1, "R10", dut_rst_o, 1);
        repeat (3) @(negedge clk);
        chk(dut_rst_o == 1'b1, "R10", dut_rst_o, 1);
    endtask

    initial begin : kicker
        int n = 0;
        forever begin
            @(negedge clk);
            n++;
            kick = kick_en && (n % 8 == 0);
        end
    end

    initial begin : hang_guard
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, actual=unfinished expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(dut_rst_o == 1'b1, "R1", dut_rst_o, 1);
        chk(!irq_o && !inj_valid_o && !run_done_o, "R1", irq_o, 0);
        chk(wd_fault_o == 1'b0, "R1", wd_fault_o, 0);
        check_counters("R1");

        // R2 configuration by kind
        for (int v = 0; v < 4; v++) begin
            cfg_write(3'd0, v, 32'(INST[v]));
            cfg_write(3'd1, v, 32'(TGTC[v]));
            cfg_write(3'd2, v, 32'(vreg(v)));
            cfg_write(3'd3, v, vmask(v));
        end
        for (int w = 0; w < NR; w++) cfg_write(3'd4, w, exp_word(w));
        cfg_write(3'd5, 0, 32'(NOM));
        cfg_write(3'd7, 0, 32'(BLIM));
        chk(dut_rst_o == 1'b1, "R2", dut_rst_o, 1);

        // table of runs, limit = NOM * default multiple 5 (R2)
        for (int r = 0; r < NROW; r++)
            do_run(T_VEC[r], T_BOOT[r], T_END[r], T_BAD[r], T_OUT[r], LIM);

        // R2 R7: multiple 2 gives limit 8
        cfg_write(3'd6, 0, 32'd2);
        do_run(0, 0, 7, -1, 3, 8);
        do_run(0, 0, 8, -1, 1, 8);

        // R11: lapse of the host refresh aborts a long run
        cfg_write(3'd5, 0, 32'd1000);
        cfg_write(3'd6, 0, 32'd15);
        @(negedge clk);
        arm = 1'b1; arm_idx = 2'd2;
        @(negedge clk);
        arm = 1'b0; boot_done = 1'b1;
        @(negedge clk);
        boot_done = 1'b0;
        chk(dut_rst_o == 1'b0, "R11", dut_rst_o, 0);
        kick_en = 1'b0;
        repeat (80) @(negedge clk);
        chk(wd_fault_o == 1'b1, "R11", wd_fault_o, 1);
        chk(dut_rst_o == 1'b1, "R11", dut_rst_o, 1);
        check_counters("R11");
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        repeat (3) @(negedge clk);
        chk(dut_rst_o == 1'b1, "R11", dut_rst_o, 1);
        chk(wd_fault_o == 1'b1, "R11", wd_fault_o, 1);
        check_counters("R11");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule